// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an internal bus that carries one request at a time to an external parallel bus. On the external bus, one set of lines carries first the address and then the data. The address space above the internal port is split into four regions of 64 MB each. Each region has its own active-low select line, so four devices can share the lines. An access first drives the address and pulses an address-latch strobe. It then lowers a read or write strobe for a programmed number of clock cycles. A device may stretch that strobe through a ready input.

The requester presents an address, write data, an access size and a direction. It receives read data, a one-cycle done pulse and a fault flag. Configuration inputs set the device width (8 or 16 bits), enable each region, and give the length of every phase in clock cycles. A request is rejected with a fault, and no external pin moves, in two cases: its size does not match the configured width, or it targets a disabled region. The address bits above the shared lines are driven on separate upper-address outputs for the whole access.

Top module: `mbus_ctrl`

## Requirements
- R1: Address bits [27:26] select the region; only `bus_cs_n[region]` goes low, and only from the first setup cycle to the last chip-select hold cycle of that access.
- R2: A request to a region whose `cfg_bank_en` bit is 0 returns done with fault one cycle after acceptance, and all select lines and strobes stay high and `bus_ad_oe` stays low.
- R3: Request size (`req_size` 0 = byte, 1 = halfword) must equal the device width (`cfg_wide` 0 = 8-bit, 1 = 16-bit). Otherwise the request faults as in R2 and no external cycle is started.
- R4: The phases run in this order: setup, latch strobe (`bus_ale` high), hold, read/write strobe, chip-select hold, then one final cycle. Each lasts its programmed count of cycles, and a count of 0 for setup, latch, hold or strobe acts as 1.
- R5: A chip-select hold count of 0 is legal. The select line then rises in the cycle right after the last strobe cycle.
- R6: When `cfg_ready_en` is 1, the strobe is held low while the ready input, seen through a two-flop synchronizer, is low. It ends only after the minimum strobe width has elapsed and in the cycle after a high synchronized ready is seen. When `cfg_ready_en` is 0, ready is ignored.
- R7: During setup, latch and hold, `bus_ad_oe` is high and `bus_ad_out` carries address bits [15:0]. For writes, the write data is driven from the first strobe cycle through the final cycle after the strobe rises. In 8-bit mode the upper byte is zero.
- R8: For reads, `bus_ad_oe` is low from the first strobe cycle on. `bus_ad_in` is captured on the last strobe cycle and returned on `rsp_rdata`, zero-extended from bits [7:0] in 8-bit mode.
- R9: `rsp_done` is high for exactly one cycle per accepted request. For good accesses this is the final cycle; `rsp_fault` is high only together with done. A `req_valid` that arrives while an access is in progress is ignored.
- R10: While reset is high, all select lines and both strobes are high, and `bus_ale`, `bus_ad_oe`, `rsp_done` and `rsp_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | 28 | Byte address; [27:26] region |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = halfword |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Fault flag, valid with done |
| rsp_rdata | output | 16 | Read data |
| cfg_wide | input | 1 | Device width: 0 = 8-bit, 1 = 16-bit |
| cfg_bank_en | input | 4 | Per-region enable |
| cfg_setup | input | 4 | Address setup cycles |
| cfg_ale | input | 4 | Latch strobe width cycles |
| cfg_hold | input | 4 | Address hold cycles |
| cfg_strobe | input | 4 | Minimum read/write strobe cycles |
| cfg_cshold | input | 4 | Chip-select hold cycles (0 allowed) |
| cfg_ready_en | input | 1 | Honour the ready input |
| bus_cs_n | output | 4 | Active-low region selects |
| bus_ale | output | 1 | Address-latch strobe |
| bus_re_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write strobe |
| bus_ad_out | output | 16 | Shared address/data lines, driven value |
| bus_ad_oe | output | 1 | Drive enable for shared lines |
| bus_ad_in | input | 16 | Shared lines, sampled value |
| bus_addr_hi | output | 10 | Address bits [25:16] |
| bus_ready | input | 1 | Device ready (high = finished) |

## Verification
The bench targets ready stretching in two cases: ready held low past the minimum strobe width, and ready already high. A controller that ignored ready, or ended the strobe without regard to synchronizer latency, would end the strobe cycles early or late. Zero-length phases and a chip-select hold of 0 are driven to catch lengths that are off by one or phases that are dropped. Faults from a width mismatch and from a disabled region are checked at the pins, since a faulty design would still pulse a select line or strobe. A request arriving while an access is in progress is also sent, and a controller that accepted it would begin a second access after done.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    localparam int ADDR_W   = 28;
    localparam int AD_W     = 16;
    localparam int PH_W     = 4;
    localparam int NBANK    = 4;
    localparam int BANK_W   = $clog2(NBANK);
    localparam int BANK_LSB = ADDR_W - BANK_W;
    localparam int HI_W     = BANK_LSB - AD_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_ALE, ST_HOLD, ST_STROBE, ST_CSHOLD, ST_END, ST_FAULT
    } phase_e;

    typedef struct packed {
        logic [PH_W-1:0] setup;
        logic [PH_W-1:0] ale;
        logic [PH_W-1:0] hold;
        logic [PH_W-1:0] strobe;
        logic [PH_W-1:0] cshold;
    } timing_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              write;
        logic [AD_W-1:0]   addr_lo;
        logic [HI_W-1:0]   addr_hi;
        logic [AD_W-1:0]   wdata;
    } xfer_t;

    function automatic logic [PH_W-1:0] at_least_one(input logic [PH_W-1:0] v);
        return (v == '0) ? PH_W'(1) : v;
    endfunction

    function automatic logic [AD_W-1:0] fit_width(input logic wide, input logic [AD_W-1:0] v);
        return wide ? v : {{(AD_W-8){1'b0}}, v[7:0]};
    endfunction
endpackage

// File: rtl/mbus_ready_sync.sv
module mbus_ready_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1;
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            q  <= 1'b0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode
    import mbus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              size,
    input  logic [AD_W-1:0]   wdata,
    input  logic              wide,
    input  logic [NBANK-1:0]  bank_en,
    output xfer_t             xfer,
    output logic              fault
);
    always_comb begin
        xfer.bank    = addr[ADDR_W-1:BANK_LSB];
        xfer.write   = write;
        xfer.addr_lo = addr[AD_W-1:0];
        xfer.addr_hi = addr[BANK_LSB-1:AD_W];
        xfer.wdata   = fit_width(wide, wdata);
        fault        = (size != wide) || !bank_en[xfer.bank];
    end
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  xfer_t            new_xfer,
    input  logic             new_fault,
    input  timing_t          tcfg,
    input  logic             cfg_wide,
    input  logic             cfg_ready_en,
    input  logic             rdy_sync,
    input  logic [AD_W-1:0]  ad_in,
    output logic [NBANK-1:0] cs_n,
    output logic             ale,
    output logic             re_n,
    output logic             we_n,
    output logic [AD_W-1:0]  ad_out,
    output logic             ad_oe,
    output logic [HI_W-1:0]  addr_hi,
    output logic             done,
    output logic             fault,
    output logic [AD_W-1:0]  rdata
);
    phase_e          state;
    xfer_t           cur;
    logic [PH_W-1:0] cnt;
    logic [PH_W-1:0] plen;
    logic            last;
    logic            active;
    logic            addr_phase;

    always_comb begin
        plen = PH_W'(1);
        case (state)
            ST_SETUP:  plen = at_least_one(tcfg.setup);
            ST_ALE:    plen = at_least_one(tcfg.ale);
            ST_HOLD:   plen = at_least_one(tcfg.hold);
            ST_STROBE: plen = at_least_one(tcfg.strobe);
            ST_CSHOLD: plen = at_least_one(tcfg.cshold);
            default:   plen = PH_W'(1);
        endcase
        last = (cnt >= plen - PH_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cur   <= '0;
            rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req_valid) begin
                        if (new_fault) begin
                            state <= ST_FAULT;
                        end else begin
                            cur   <= new_xfer;
                            state <= ST_SETUP;
                        end
                    end
                end
                ST_SETUP, ST_ALE, ST_HOLD, ST_CSHOLD: begin
                    if (last) begin
                        cnt <= '0;
                        case (state)
                            ST_SETUP: state <= ST_ALE;
                            ST_ALE:   state <= ST_HOLD;
                            ST_HOLD:  state <= ST_STROBE;
                            default:  state <= ST_END;
                        endcase
                    end else begin
                        cnt <= cnt + PH_W'(1);
                    end
                end
                ST_STROBE: begin
                    if (last && (!cfg_ready_en || rdy_sync)) begin
                        cnt <= '0;
                        if (!cur.write) rdata <= fit_width(cfg_wide, ad_in);
                        state <= (tcfg.cshold == '0) ? ST_END : ST_CSHOLD;
                    end else if (!last) begin
                        cnt <= cnt + PH_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign active     = (state == ST_SETUP) || (state == ST_ALE) || (state == ST_HOLD) ||
                        (state == ST_STROBE) || (state == ST_CSHOLD);
    assign addr_phase = (state == ST_SETUP) || (state == ST_ALE) || (state == ST_HOLD);

    genvar gi;
    generate
        for (gi = 0; gi < NBANK; gi++) begin : g_cs
            assign cs_n[gi] = !(active && (cur.bank == BANK_W'(gi)));
        end
    endgenerate

    assign ale     = (state == ST_ALE);
    assign re_n    = !((state == ST_STROBE) && !cur.write);
    assign we_n    = !((state == ST_STROBE) && cur.write);
    assign ad_oe   = addr_phase || (cur.write &&
                     ((state == ST_STROBE) || (state == ST_CSHOLD) || (state == ST_END)));
    assign ad_out  = addr_phase ? cur.addr_lo : cur.wdata;
    assign addr_hi = cur.addr_hi;
    assign done    = (state == ST_END) || (state == ST_FAULT);
    assign fault   = (state == ST_FAULT);

    assert_one_select_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    assert_strobe_has_select_R4: assert property (@(posedge clk) disable iff (rst)
        (!re_n || !we_n) |-> !(&cs_n));
    assert_no_dual_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !(!re_n && !we_n) && !(ale && (!re_n || !we_n)));
    assert_fault_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        fault |-> (&cs_n && re_n && we_n && !ad_oe && done));
    assert_ready_holds_R6: assert property (@(posedge clk) disable iff (rst)
        ((!re_n || !we_n) && cfg_ready_en && !rdy_sync) |=> (!re_n || !we_n));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_read_released_R8: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !ad_oe);
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_size,
    input  logic [AD_W-1:0]   req_wdata,
    output logic              rsp_done,
    output logic              rsp_fault,
    output logic [AD_W-1:0]   rsp_rdata,
    input  logic              cfg_wide,
    input  logic [NBANK-1:0]  cfg_bank_en,
    input  logic [PH_W-1:0]   cfg_setup,
    input  logic [PH_W-1:0]   cfg_ale,
    input  logic [PH_W-1:0]   cfg_hold,
    input  logic [PH_W-1:0]   cfg_strobe,
    input  logic [PH_W-1:0]   cfg_cshold,
    input  logic              cfg_ready_en,
    output logic [NBANK-1:0]  bus_cs_n,
    output logic              bus_ale,
    output logic              bus_re_n,
    output logic              bus_we_n,
    output logic [AD_W-1:0]   bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [AD_W-1:0]   bus_ad_in,
    output logic [HI_W-1:0]   bus_addr_hi,
    input  logic              bus_ready
);
    xfer_t   dec_xfer;
    logic    dec_fault;
    logic    rdy_sync;
    timing_t tcfg;

    assign tcfg = '{setup: cfg_setup, ale: cfg_ale, hold: cfg_hold,
                    strobe: cfg_strobe, cshold: cfg_cshold};

    mbus_decode u_dec (
        .addr(req_addr), .write(req_write), .size(req_size), .wdata(req_wdata),
        .wide(cfg_wide), .bank_en(cfg_bank_en), .xfer(dec_xfer), .fault(dec_fault)
    );

    mbus_ready_sync u_sync (.clk(clk), .rst(rst), .d(bus_ready), .q(rdy_sync));

    mbus_seq u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .new_xfer(dec_xfer),
        .new_fault(dec_fault), .tcfg(tcfg), .cfg_wide(cfg_wide),
        .cfg_ready_en(cfg_ready_en), .rdy_sync(rdy_sync), .ad_in(bus_ad_in),
        .cs_n(bus_cs_n), .ale(bus_ale), .re_n(bus_re_n), .we_n(bus_we_n),
        .ad_out(bus_ad_out), .ad_oe(bus_ad_oe), .addr_hi(bus_addr_hi),
        .done(rsp_done), .fault(rsp_fault), .rdata(rsp_rdata)
    );
endmodule

// File: tb/sim_mbus_ctrl.sv
module sim_mbus_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [27:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_size = 1'b1;
    logic [15:0] req_wdata = '0;
    logic        rsp_done, rsp_fault;
    logic [15:0] rsp_rdata;
    logic        cfg_wide = 1'b1;
    logic [3:0]  cfg_bank_en = 4'hF;
    logic [3:0]  cfg_setup = 4'd1, cfg_ale = 4'd1, cfg_hold = 4'd1;
    logic [3:0]  cfg_strobe = 4'd1, cfg_cshold = 4'd1;
    logic        cfg_ready_en = 1'b0;
    logic [3:0]  bus_cs_n;
    logic        bus_ale, bus_re_n, bus_we_n, bus_ad_oe;
    logic [15:0] bus_ad_out;
    logic [15:0] bus_ad_in = '0;
    logic [9:0]  bus_addr_hi;
    logic        bus_ready = 1'b1;

    int checks = 0;
    int fails  = 0;

    typedef struct packed {
        logic [3:0]  cs;
        logic        ale, re_n, we_n, oe;
        logic [15:0] ad;
        logic [9:0]  hi;
        logic        done, fault;
    } exp_t;

    always #5 clk = ~clk;

    mbus_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .cfg_wide(cfg_wide), .cfg_bank_en(cfg_bank_en), .cfg_setup(cfg_setup),
        .cfg_ale(cfg_ale), .cfg_hold(cfg_hold), .cfg_strobe(cfg_strobe),
        .cfg_cshold(cfg_cshold), .cfg_ready_en(cfg_ready_en),
        .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_re_n(bus_re_n),
        .bus_we_n(bus_we_n), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_ad_in(bus_ad_in), .bus_addr_hi(bus_addr_hi), .bus_ready(bus_ready)
    );

    function automatic int len1(input logic [3:0] v);
        return (v == 4'd0) ? 1 : int'(v);
    endfunction

    function automatic exp_t idle_vec();
        exp_t e;
        e = '0;
        e.cs = 4'hF; e.re_n = 1'b1; e.we_n = 1'b1;
        return e;
    endfunction

    task automatic compare(input exp_t e, input string tag);
        logic bad;
        bad = (bus_cs_n != e.cs) || (bus_ale != e.ale) || (bus_re_n != e.re_n) ||
              (bus_we_n != e.we_n) || (bus_ad_oe != e.oe) || (rsp_done != e.done) ||
              (rsp_fault != e.fault) || (e.oe && (bus_ad_out != e.ad)) ||
              ((e.cs != 4'hF) && (bus_addr_hi != e.hi));
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s pins actual cs=%h ale=%b re=%b we=%b oe=%b ad=%h hi=%h done=%b flt=%b expected cs=%h ale=%b re=%b we=%b oe=%b ad=%h hi=%h done=%b flt=%b",
                     tag, bus_cs_n, bus_ale, bus_re_n, bus_we_n, bus_ad_oe, bus_ad_out,
                     bus_addr_hi, rsp_done, rsp_fault, e.cs, e.ale, e.re_n, e.we_n,
                     e.oe, e.ad, e.hi, e.done, e.fault);
        end
    endtask

    task automatic run(input logic [27:0] addr, input logic wr, input logic sz,
                       input logic [15:0] wd, input logic [15:0] rin,
                       input int rdy_from, input bit poke, input string tag);
        exp_t q[$];
        exp_t e;
        logic [1:0]  bk;
        logic        flt;
        logic [15:0] wdx, rdx;
        int          c, j;
        bit          fin;
        bk  = addr[27:26];
        flt = (sz != cfg_wide) || !cfg_bank_en[bk];
        wdx = cfg_wide ? wd : {8'h00, wd[7:0]};
        rdx = cfg_wide ? rin : {8'h00, rin[7:0]};
        if (flt) begin
            e = idle_vec(); e.done = 1'b1; e.fault = 1'b1;
            q.push_back(e);
        end else begin
            e = idle_vec();
            e.cs = ~(4'b0001 << bk); e.oe = 1'b1; e.ad = addr[15:0]; e.hi = addr[25:16];
            for (int i = 0; i < len1(cfg_setup); i++) q.push_back(e);
            e.ale = 1'b1;
            for (int i = 0; i < len1(cfg_ale); i++) q.push_back(e);
            e.ale = 1'b0;
            for (int i = 0; i < len1(cfg_hold); i++) q.push_back(e);
            e.re_n = wr; e.we_n = !wr; e.oe = wr; e.ad = wdx;
            c = q.size(); j = 0; fin = 0;
            while (!fin) begin
                q.push_back(e);
                fin = (j >= len1(cfg_strobe) - 1) && (!cfg_ready_en || (c - 2 >= rdy_from));
                j++; c++;
            end
            e.re_n = 1'b1; e.we_n = 1'b1;
            for (int i = 0; i < int'(cfg_cshold); i++) q.push_back(e);
            e.cs = 4'hF; e.done = 1'b1;
            q.push_back(e);
        end
        q.push_back(idle_vec());

        if (rdy_from > 0) begin
            @(negedge clk); bus_ready = 1'b0;
            repeat (3) @(negedge clk);
        end else begin
            @(negedge clk);
        end
        req_addr = addr; req_write = wr; req_size = sz; req_wdata = wd;
        bus_ad_in = rin; req_valid = 1'b1;
        @(posedge clk);
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            if (i == 0) req_valid = 1'b0;
            if (poke && i == 2) begin
                req_valid = 1'b1; req_addr = 28'h4000010; req_write = 1'b0;
            end
            if (poke && i == 3) req_valid = 1'b0;
            bus_ready = (i >= rdy_from);
            compare(q[i], tag);
            if (q[i].done && !q[i].fault && !wr) begin
                checks++;
                if (rsp_rdata != rdx) begin
                    fails++;
                    $display("FAIL %s rdata actual=%h expected=%h", tag, rsp_rdata, rdx);
                end
            end
        end
        bus_ready = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (bus_cs_n != 4'hF || !bus_re_n || !bus_we_n || bus_ale || bus_ad_oe ||
            rsp_done || rsp_fault) begin
            fails++;
            $display("FAIL R10 reset actual cs=%h re=%b we=%b ale=%b oe=%b done=%b flt=%b expected cs=f re=1 we=1 ale=0 oe=0 done=0 flt=0",
                     bus_cs_n, bus_re_n, bus_we_n, bus_ale, bus_ad_oe, rsp_done, rsp_fault);
        end
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R7: 16-bit write, unit phases
        run(28'h0001234, 1'b1, 1'b1, 16'hBEEF, 16'h0000, -10, 1'b0, "R7");
        // R9: request during a busy access is ignored
        run(28'h4005678, 1'b1, 1'b1, 16'hC0DE, 16'h0000, -10, 1'b1, "R9");
        // R5: read, stretched phases, zero chip-select hold
        cfg_setup = 4'd2; cfg_ale = 4'd3; cfg_hold = 4'd1; cfg_strobe = 4'd2; cfg_cshold = 4'd0;
        run(28'h8003344, 1'b0, 1'b1, 16'h0000, 16'h1357, -10, 1'b0, "R5");
        // R4: zero counts act as one, 8-bit write
        cfg_wide = 1'b0; cfg_setup = 4'd0; cfg_ale = 4'd0; cfg_hold = 4'd0;
        cfg_strobe = 4'd0; cfg_cshold = 4'd2;
        run(28'hC02A5A1, 1'b1, 1'b0, 16'hFF77, 16'h0000, -10, 1'b0, "R4");
        // R8: 8-bit read zero-extends
        cfg_setup = 4'd1; cfg_ale = 4'd1; cfg_hold = 4'd2; cfg_strobe = 4'd3; cfg_cshold = 4'd1;
        run(28'h4000100, 1'b0, 1'b0, 16'h0000, 16'hA55A, -10, 1'b0, "R8");
        // R3: size mismatch faults
        cfg_wide = 1'b1;
        run(28'h0000002, 1'b0, 1'b0, 16'h0000, 16'h0000, -10, 1'b0, "R3");
        // R2: disabled region faults
        cfg_bank_en = 4'b1101;
        run(28'h4000004, 1'b1, 1'b1, 16'h1111, 16'h0000, -10, 1'b0, "R2");
        cfg_bank_en = 4'hF;
        // R6: ready low past minimum width
        cfg_ready_en = 1'b1; cfg_setup = 4'd1; cfg_ale = 4'd1; cfg_hold = 4'd1;
        cfg_strobe = 4'd2; cfg_cshold = 4'd1;
        run(28'h8000222, 1'b0, 1'b1, 16'h0000, 16'h2468, 8, 1'b0, "R6");
        // R6: ready already high, minimum width only
        run(28'h0000444, 1'b1, 1'b1, 16'h3C3C, 16'h0000, -10, 1'b0, "R6");
        // R6: ready ignored when disabled
        cfg_ready_en = 1'b0;
        run(28'h4000666, 1'b1, 1'b1, 16'h5A5A, 16'h0000, 6, 1'b0, "R6");
        // R1: upper region with upper address bits set
        run(28'hFFF0F0F, 1'b0, 1'b1, 16'h0000, 16'h9ABC, -10, 1'b0, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule